// File: doc/BRIEF.md
# Cascaded Audio Serial Clock Generator

This block turns a free-running audio master clock into two slower audio clocks. The first is a serial bit clock. The second is a left/right word clock. Two programmable divider stages are chained. The first stage counts edges of the master clock. The second stage counts edges of the bit clock that the first stage produces. Each stage has a phase bit that picks which edge of its own input clock it counts and aligns its transitions to: the rising edge or the falling edge.

The whole block runs in one fast system clock domain. The master clock arrives on an ordinary input, passes through a short synchronizer, and its edges are detected as single-cycle strobes. The generated clocks are registered outputs. The divisors and phase bits sit in a small register bank that is loaded through a one-cycle address/data write port.

Top module: `aud_clk_cascade`

## Requirements
- R1: While `rst_ni` is low at a clock edge, both clock outputs go low, both counters clear, and all divisor and phase registers return to zero. With zero divisors the outputs then stay low.
- R2: A bit-clock divisor N (data bits [5:0] written at address 0x38) makes `bclk_o` toggle once every N selected master-clock edges. This gives a period of 2N master-clock periods at a 50% duty cycle.
- R3: Phase bit 0 at address 0x3A selects the master-clock edge that `bclk_o` follows (0 = rising, 1 = falling). Each `bclk_o` transition appears exactly SYNC_STAGES+1 system-clock cycles after the selected master-clock transition is presented.
- R4: A word-clock divisor M (data bits [5:0] written at address 0x39) makes `lrclk_o` toggle once every M selected edges of the bit clock. This gives a period of 2M bit-clock periods.
- R5: Phase bit 1 at address 0x3A selects the bit-clock edge that `lrclk_o` follows (0 = rising, 1 = falling). Each `lrclk_o` transition appears exactly one system-clock cycle after that bit-clock transition.
- R6: A divisor of zero holds that stage's output low. If the output is high when zero is written, it falls at the end of the running half-period.
- R7: A new divisor is applied only when the running half-period completes. The half-period in progress keeps the old length, and the next one has the new length.
- R8: A write with `wr_en_i` low, or to any address other than 0x38, 0x39 or 0x3A, changes nothing. Data bits [7:6] of a divisor write and bits [7:2] of a phase write are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the master clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| mclk_i | input | 1 | Audio master clock, sampled asynchronously |
| wr_en_i | input | 1 | Write strobe for the register bank |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| bclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Left/right word clock |

## Verification
On every cycle, the assertions check the following:
- An edge detector never reports a rising and a falling edge together.
- A divider output moves only on a counted edge, and its count stays below the active divisor.
- The active divisor is reloaded only at a half-period boundary.
- Writes that miss the register map leave the bank untouched.
- Every word-clock transition follows a bit-clock transition by one cycle.

Some behaviours depend on the programmed values, so only the bench scenarios can show them. These are the exact period lengths for each divisor, which master-clock or bit-clock polarity the outputs line up with, the fixed latency from the master-clock edge, the low hold for zero divisors, and the old-then-new half-period sequence after a write made while the clocks run.

// File: rtl/acg_pkg.sv
package acg_pkg;

   // Edge polarity counted by a divider stage
   typedef enum logic {
      ACG_EDGE_RISE = 1'b0,
      ACG_EDGE_FALL = 1'b1
   } acg_edge_e;

   // Number of cascaded divider stages (bit clock, word clock)
   localparam int unsigned ACG_NUM_STAGES = 2;

   function automatic logic acg_pick_edge(input acg_edge_e sel,
                                          input logic rise,
                                          input logic fall);
      return (sel == ACG_EDGE_FALL) ? fall : rise;
   endfunction

endpackage

// File: rtl/acg_regbank.sv
module acg_regbank
   import acg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DIV_W      = 6,
   parameter int unsigned NUM_STAGES = ACG_NUM_STAGES,
   parameter logic [ADDR_W-1:0] DIV_BASE_ADDR = 'h38,
   parameter logic [ADDR_W-1:0] PHASE_ADDR    = 'h3A
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              wr_en_i,
   input  logic [ADDR_W-1:0]                 wr_addr_i,
   input  logic [DATA_W-1:0]                 wr_data_i,
   output logic [NUM_STAGES-1:0][DIV_W-1:0]  div_o,
   output logic [NUM_STAGES-1:0]             phase_o
);

   localparam int unsigned LAST_DIV_ADDR = int'(DIV_BASE_ADDR) + NUM_STAGES - 1;

   initial begin
      assert (DIV_W >= 1 && DIV_W <= DATA_W)
         else $fatal(1, "acg_regbank: DIV_W must fit in DATA_W");
      assert (NUM_STAGES >= 1 && NUM_STAGES <= DATA_W)
         else $fatal(1, "acg_regbank: phase bits must fit in DATA_W");
      assert (int'(PHASE_ADDR) < int'(DIV_BASE_ADDR) || int'(PHASE_ADDR) > LAST_DIV_ADDR)
         else $fatal(1, "acg_regbank: phase address overlaps divisor addresses");
      assert (LAST_DIV_ADDR < (1 << ADDR_W))
         else $fatal(1, "acg_regbank: divisor addresses exceed address space");
   end

   logic [NUM_STAGES-1:0] div_hit;
   logic                  phase_hit;
   logic                  any_hit;
   logic                  unused_wr_data;

   assign unused_wr_data = ^wr_data_i;

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_div
      localparam logic [ADDR_W-1:0] STAGE_ADDR = ADDR_W'(int'(DIV_BASE_ADDR) + s);
      logic [DIV_W-1:0] div_q;

      assign div_hit[s] = wr_en_i && (wr_addr_i == STAGE_ADDR);

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            div_q <= '0;
         end else if (div_hit[s]) begin
            div_q <= wr_data_i[DIV_W-1:0];
         end
      end

      assign div_o[s] = div_q;
   end

   assign phase_hit = wr_en_i && (wr_addr_i == PHASE_ADDR);
   assign any_hit   = phase_hit || (|div_hit);

   logic [NUM_STAGES-1:0] phase_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q <= '0;
      end else if (phase_hit) begin
         phase_q <= wr_data_i[NUM_STAGES-1:0];
      end
   end

   assign phase_o = phase_q;

   // R8
   stray_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_hit |=> ($stable(div_o) && $stable(phase_o)));

endmodule

// File: rtl/acg_edge_det.sv
module acg_edge_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sig_i,
   output logic rise_o,
   output logic fall_o
);

   initial begin
      assert (SYNC_STAGES <= 8)
         else $fatal(1, "acg_edge_det: SYNC_STAGES out of range");
   end

   logic level;

   if (SYNC_STAGES == 0) begin : g_direct
      assign level = sig_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            sync_q <= '0;
         end else begin
            sync_q[0] <= sig_i;
            for (int i = 1; i < int'(SYNC_STAGES); i++) begin
               sync_q[i] <= sync_q[i-1];
            end
         end
      end

      assign level = sync_q[SYNC_STAGES-1];
   end

   logic prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= level;
      end
   end

   assign rise_o = level & ~prev_q;
   assign fall_o = ~level & prev_q;

   // R3
   single_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rise_o, fall_o}));

endmodule

// File: rtl/acg_divider.sv
module acg_divider
   import acg_pkg::*;
#(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic             phase_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             clk_o
);

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 16)
         else $fatal(1, "acg_divider: DIV_W out of range");
   end

   logic             tick;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] act_q;
   logic             out_q;
   logic             idle;
   logic             half_done;

   assign tick      = acg_pick_edge(acg_edge_e'(phase_i), rise_i, fall_i);
   assign idle      = (act_q == '0);
   assign half_done = !idle && (cnt_q == act_q - 1'b1);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         act_q <= '0;
         out_q <= 1'b0;
      end else if (tick) begin
         if (idle || half_done) begin
            act_q <= div_i;
            cnt_q <= '0;
            out_q <= (idle || div_i == '0) ? 1'b0 : ~out_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign clk_o = out_q;

   // R2
   hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick |=> $stable(clk_o));

   // R2
   count_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !idle |-> (cnt_q < act_q));

   // R7
   reload_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick || (!idle && !half_done)) |=> $stable(act_q));

endmodule

// File: rtl/aud_clk_cascade.sv
module aud_clk_cascade
   import acg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] DIV_BASE_ADDR = 'h38,
   parameter logic [ADDR_W-1:0] PHASE_ADDR    = 'h3A
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mclk_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              bclk_o,
   output logic              lrclk_o
);

   localparam int unsigned NUM_STAGES = ACG_NUM_STAGES;

   initial begin
      assert (NUM_STAGES == 2)
         else $fatal(1, "aud_clk_cascade: exactly two stages expected");
   end

   logic [NUM_STAGES-1:0][DIV_W-1:0] div;
   logic [NUM_STAGES-1:0]            phase;
   logic [NUM_STAGES-1:0]            stage_in;
   logic [NUM_STAGES-1:0]            stage_out;

   acg_regbank #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .DIV_W         (DIV_W),
      .NUM_STAGES    (NUM_STAGES),
      .DIV_BASE_ADDR (DIV_BASE_ADDR),
      .PHASE_ADDR    (PHASE_ADDR)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .div_o     (div),
      .phase_o   (phase)
   );

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      // first stage sees an asynchronous clock, later stages a local register
      localparam int unsigned SYNC_N = (s == 0) ? SYNC_STAGES : 0;
      logic rise;
      logic fall;

      if (s == 0) begin : g_src_ext
         assign stage_in[s] = mclk_i;
      end else begin : g_src_prev
         assign stage_in[s] = stage_out[s-1];
      end

      acg_edge_det #(
         .SYNC_STAGES (SYNC_N)
      ) u_edge (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .sig_i  (stage_in[s]),
         .rise_o (rise),
         .fall_o (fall)
      );

      acg_divider #(
         .DIV_W (DIV_W)
      ) u_div (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .rise_i  (rise),
         .fall_i  (fall),
         .phase_i (phase[s]),
         .div_i   (div[s]),
         .clk_o   (stage_out[s])
      );
   end

   assign bclk_o  = stage_out[0];
   assign lrclk_o = stage_out[1];

   // R5
   word_follows_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lrclk_o != $past(lrclk_o)) |-> ($past(bclk_o) != $past(bclk_o, 2)));

endmodule

// File: tb/aud_clk_cascade_bench.sv
module aud_clk_cascade_bench;

   localparam int SYNC  = 2;
   localparam int LAT   = SYNC + 1;
   localparam int MHALF = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mclk = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       bclk;
   logic       lrclk;

   aud_clk_cascade #(.SYNC_STAGES(SYNC)) u_aud_clk_cascade (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .mclk_i    (mclk),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .bclk_o    (bclk),
      .lrclk_o   (lrclk)
   );

   always #2 clk = ~clk;

   int ncyc = 0;
   always @(posedge clk) ncyc <= ncyc + 1;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      int    bhalf;
      int    lhalf;
      bit    bph;
      bit    lph;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   done_cnt = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // free-running master clock, period 2*MHALF system cycles
   initial begin
      forever begin
         repeat (MHALF) @(posedge clk);
         #1 mclk = ~mclk;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk);
      #1 wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   // driver: push expected timing, wait for the monitor to consume it
   task automatic expect_cfg(int bdiv, int ldiv, bit bph, bit lph, string tag);
      exp_t it;
      int target;
      it.bhalf = bdiv * 2 * MHALF;
      it.lhalf = ldiv * 2 * it.bhalf;
      it.bph   = bph;
      it.lph   = lph;
      it.tag   = tag;
      target   = done_cnt + 1;
      exp_q.push_back(it);
      while (done_cnt < target) @(negedge clk);
   endtask

   task automatic measure(exp_t it);
      int pm, pb, pl, m, b, l, c, start;
      int last_m = -1000, last_b = -1000, last_bt = 0, last_lt = 0;
      int nb = 0, nl = 0, lr_bad = 0, bad = 0;
      if (it.bhalf == 0) begin
         repeat (300) @(negedge clk);
         for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bclk || lrclk) bad++;
         end
         check(bad == 0, it.tag, "samples with an output high under zero divisor", bad, 0);
         return;
      end
      @(negedge clk);
      pm = mclk; pb = bclk; pl = lrclk;
      start = ncyc;
      forever begin
         @(negedge clk);
         c = ncyc; m = mclk; b = bclk; l = lrclk;
         if (c - start > 30000) begin
            check(1'b0, it.tag, "measurement timeout cycles", c - start, 30000);
            return;
         end
         if (m != pm) last_m = c;
         if (l != pl) begin
            nl++;
            if (nl >= 3) begin
               check(c - last_b == 1, "R5", "lrclk delay after bclk edge", c - last_b, 1);
               check(b == !it.lph, "R5", "bclk level at lrclk edge", b, !it.lph);
            end
            if (nl >= 4)
               check(c - last_lt == it.lhalf, "R4", "lrclk half-period", c - last_lt, it.lhalf);
            if (nl >= 3) last_lt = c;
         end
         if (b != pb) begin
            nb++;
            if (nb >= 2) begin
               check(c - last_m == LAT, "R3", "bclk delay after mclk edge", c - last_m, LAT);
               check(m == !it.bph, "R3", "mclk level at bclk edge", m, !it.bph);
            end
            if (nb >= 3)
               check(c - last_bt == it.bhalf, "R2", "bclk half-period", c - last_bt, it.bhalf);
            if (nb >= 2) last_bt = c;
            last_b = c;
         end
         if (it.lhalf == 0 && nb >= 6 && l != 0) lr_bad++;
         pm = m; pb = b; pl = l;
         if (it.lhalf == 0 && nb >= 10) break;
         if (it.lhalf != 0 && nl >= 5) break;
      end
      if (it.lhalf == 0)
         check(lr_bad == 0, "R6", "lrclk high samples with zero word divisor", lr_bad, 0);
   endtask

   // monitor: pop expected items and compare against observed outputs
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            measure(it);
            done_cnt++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "WDOG", "watchdog expired at cycle", ncyc, 150000);
      summary();
   end

   initial begin
      int t0, t1, t2, pb, guard, highs;
      // R1: outputs low in and after reset
      repeat (5) @(negedge clk);
      check(!bclk && !lrclk, "R1", "outputs during reset", {bclk, lrclk}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (50) @(negedge clk);
      check(!bclk && !lrclk, "R1", "outputs after reset with cleared divisors", {bclk, lrclk}, 0);

      // R8: strobe low and unmapped addresses do nothing
      @(posedge clk); #1 wr_en = 1'b0; wr_addr = 8'h38; wr_data = 8'h03;
      repeat (3) @(posedge clk);
      wr(8'h3B, 8'h03);
      wr(8'h37, 8'h03);
      expect_cfg(0, 0, 0, 0, "R8");

      // R2/R4/R8: upper data bits ignored (0xC2 -> divisor 2)
      wr(8'h38, 8'hC2); wr(8'h39, 8'h03); wr(8'h3A, 8'h00);
      expect_cfg(2, 3, 0, 0, "R2");

      // R3/R8: phase write 0xFD -> bit clock on falling, word on rising
      wr(8'h38, 8'h01); wr(8'h39, 8'h04); wr(8'h3A, 8'hFD);
      expect_cfg(1, 4, 1, 0, "R3");

      // R5: word clock on falling bit-clock edge
      wr(8'h38, 8'h03); wr(8'h39, 8'h02); wr(8'h3A, 8'h02);
      expect_cfg(3, 2, 0, 1, "R5");

      // R3/R5: both stages on falling edges
      wr(8'h3A, 8'h03);
      expect_cfg(3, 2, 1, 1, "R3");

      // R6: zero word divisor, then zero bit divisor
      wr(8'h39, 8'h00);
      expect_cfg(3, 0, 1, 1, "R6");
      wr(8'h38, 8'h00);
      expect_cfg(0, 0, 1, 1, "R6");

      // R7: divisor change while running
      wr(8'h3A, 8'h00); wr(8'h38, 8'h03);
      repeat (200) @(negedge clk);
      pb = bclk; guard = 0;
      do begin @(negedge clk); guard++; end while (bclk == pb && guard < 1000);
      t0 = ncyc;
      repeat (8) @(negedge clk);
      wr(8'h38, 8'h05);
      pb = bclk; guard = 0;
      do begin @(negedge clk); guard++; end while (bclk == pb && guard < 1000);
      t1 = ncyc;
      check(t1 - t0 == 30, "R7", "half-period in progress at write", t1 - t0, 30);
      pb = bclk; guard = 0;
      do begin @(negedge clk); guard++; end while (bclk == pb && guard < 1000);
      t2 = ncyc;
      check(t2 - t1 == 50, "R7", "first half-period after write", t2 - t1, 50);

      // R1: reset while running clears everything
      wr(8'h38, 8'h01); wr(8'h39, 8'h01);
      repeat (100) @(negedge clk);
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(!bclk && !lrclk, "R1", "outputs during mid-run reset", {bclk, lrclk}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      highs = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (bclk || lrclk) highs++;
      end
      check(highs == 0, "R1", "high samples after reset cleared registers", highs, 0);

      summary();
   end

endmodule